// File: doc/BRIEF.md
# Instrument Status Byte with Service Request

This block builds an instrument's eight-bit status byte from summary levels supplied by the rest of the instrument. Those levels are an operation summary flag, a response-queue-not-empty flag and an error-queue-not-empty flag. The block also reduces two masked registers to one bit each: the standard event register with its enable mask, and the ready register with its enable mask. A writable service request enable register selects which status bits may raise a request. The block drives a service request line when the enabled summary goes from clear to set.

The byte can be read in two ways. A query read returns a live master summary in bit 6. A serial-poll read returns a latched requested-service flag in bit 6 and then clears that flag. Clearing the flag releases the request line. Every other bit is the same on both paths. Command parsing, the queues and the operation status hierarchy are outside the block. Their results arrive as input levels.

Top module: `svc_status_top`

## Requirements
- R1: Status bit positions: bit 7 = operation summary input, bit 5 = event summary, bit 4 = response queue not empty, bit 2 = error queue not empty, bit 0 = ready summary.
- R2: Bits 3 and 1 always read 0 on both read paths.
- R3: The event summary (bit 5) is 1 when some bit of the standard event register is set and its enable bit is also set. The ready summary (bit 0) is formed the same way from the ready register and its mask.
- R4: A write strobe loads the service request enable register, with one enable per status bit. The enable at position 6 never contributes to a request. Reset clears the register.
- R5: The master summary is the OR over bits 7, 5, 4, 3, 2, 1 and 0 of (status bit AND enable bit). A query read captures the status byte with the master summary in bit 6. With enable value 0x14, the summary is set whenever bit 4 or bit 2 is set.
- R6: The request line rises one clock edge after the master summary goes from 0 to 1 while the requested-service flag is clear. The flag and the line are the same state.
- R7: A serial-poll read captures the status byte with the requested-service flag in bit 6, as it was before the poll, and clears the flag and the line.
- R8: After a poll, the line stays low while the master summary stays high. It rises again only on a fresh 0 to 1 transition of the summary.
- R9: Apart from bit 6, a query read and a poll read of the same status give the same byte.
- R10: A synchronous active-high reset clears the request line, the flag, the enable register and both read data registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_sum_i | input | 1 | Operation summary level |
| evt_reg_i | input | EVT_W | Standard event register contents |
| evt_en_i | input | EVT_W | Standard event enable mask |
| rsp_pending_i | input | 1 | Response queue not empty |
| err_pending_i | input | 1 | Error queue not empty |
| rdy_reg_i | input | RDY_W | Ready register contents |
| rdy_en_i | input | RDY_W | Ready enable mask |
| sre_wr_i | input | 1 | Write strobe for the request enable register |
| sre_wdata_i | input | 8 | Request enable write value |
| qry_rd_i | input | 1 | Query read strobe |
| poll_rd_i | input | 1 | Serial-poll read strobe |
| qry_data_o | output | 8 | Byte captured by the last query read |
| poll_data_o | output | 8 | Byte captured by the last poll read |
| srq_o | output | 1 | Service request line |

## Verification
Input levels reach the summary bits through combinational logic only. An enable write takes effect at the next edge, so a query issued one cycle after the write sees the new mask. Read data appears one edge after its strobe. The request line rises one edge after the summary input changes, and it falls on the edge that takes the poll. The bench drives inputs on the falling edge and samples on the next falling edge after the edge that must change an output. It also checks the line just before that edge, to confirm that the request is not early.

// File: rtl/svc_pkg.sv
package svc_pkg;
    localparam int SB_W     = 8;
    localparam int POS_RDY  = 0;
    localparam int POS_RSV  = 1;
    localparam int POS_ERR  = 2;
    localparam int POS_QST  = 3;
    localparam int POS_MAV  = 4;
    localparam int POS_ESB  = 5;
    localparam int POS_SVC  = 6;
    localparam int POS_OPS  = 7;
    localparam logic [SB_W-1:0] SVC_MASK = SB_W'(1) << POS_SVC;

    typedef struct packed {
        logic [SB_W-1:0] sre;
        logic            rqs;
        logic            mss_prev;
        logic [SB_W-1:0] qry;
        logic [SB_W-1:0] poll;
    } ctrl_state_t;
endpackage

// File: rtl/svc_mask_summary.sv
module svc_mask_summary #(
    parameter int W = 8
) (
    input  logic [W-1:0] flags_i,
    input  logic [W-1:0] mask_i,
    output logic         hit_o
);
    logic [W-1:0] masked;
    logic         any_d;

    for (genvar g = 0; g < W; g++) begin : g_and
        assign masked[g] = flags_i[g] & mask_i[g];
    end

    always_comb begin
        any_d = 1'b0;
        for (int k = 0; k < W; k++) begin
            any_d = any_d | masked[k];
        end
    end

    assign hit_o = any_d;
endmodule

// File: rtl/svc_byte_builder.sv
module svc_byte_builder
    import svc_pkg::*;
#(
    parameter int EVT_W = 8,
    parameter int RDY_W = 8
) (
    input  logic             op_sum_i,
    input  logic [EVT_W-1:0] evt_reg_i,
    input  logic [EVT_W-1:0] evt_en_i,
    input  logic             rsp_pending_i,
    input  logic             err_pending_i,
    input  logic [RDY_W-1:0] rdy_reg_i,
    input  logic [RDY_W-1:0] rdy_en_i,
    output logic [SB_W-1:0]  base_o
);
    logic esb_hit;
    logic rdy_hit;

    svc_mask_summary #(.W(EVT_W)) u_evt_sum (
        .flags_i (evt_reg_i),
        .mask_i  (evt_en_i),
        .hit_o   (esb_hit)
    );

    svc_mask_summary #(.W(RDY_W)) u_rdy_sum (
        .flags_i (rdy_reg_i),
        .mask_i  (rdy_en_i),
        .hit_o   (rdy_hit)
    );

    always_comb begin
        base_o          = '0;
        base_o[POS_OPS] = op_sum_i;
        base_o[POS_ESB] = esb_hit;
        base_o[POS_MAV] = rsp_pending_i;
        base_o[POS_ERR] = err_pending_i;
        base_o[POS_RDY] = rdy_hit;
    end

    // R3: an unmasked event flag alone can never raise the event summary
    always_comb begin
        a_r3_esb_needs_enable: assert ((evt_en_i != '0) || !base_o[POS_ESB]);
    end
endmodule

// File: rtl/svc_request_ctrl.sv
module svc_request_ctrl
    import svc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [SB_W-1:0] base_i,
    input  logic            sre_wr_i,
    input  logic [SB_W-1:0] sre_wdata_i,
    input  logic            qry_rd_i,
    input  logic            poll_rd_i,
    output logic [SB_W-1:0] qry_data_o,
    output logic [SB_W-1:0] poll_data_o,
    output logic            srq_o
);
    ctrl_state_t st_q, st_d;
    logic        mss;
    logic        mss_rise;

    always_comb begin
        st_d     = st_q;
        mss      = |(base_i & st_q.sre & ~SVC_MASK);
        mss_rise = mss & ~st_q.mss_prev;

        st_d.mss_prev = mss;
        if (sre_wr_i) begin
            st_d.sre = sre_wdata_i & ~SVC_MASK;
        end
        if (st_q.rqs) begin
            st_d.rqs = ~poll_rd_i;
        end else begin
            st_d.rqs = mss_rise;
        end
        if (qry_rd_i) begin
            st_d.qry          = base_i;
            st_d.qry[POS_SVC] = mss;
        end
        if (poll_rd_i) begin
            st_d.poll          = base_i;
            st_d.poll[POS_SVC] = st_q.rqs;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign qry_data_o  = st_q.qry;
    assign poll_data_o = st_q.poll;
    assign srq_o       = st_q.rqs;

    a_r6_srq_follows_summary: assert property (@(posedge clk) disable iff (rst)
        $rose(srq_o) |-> $past(mss));
    a_r7_poll_drops_srq: assert property (@(posedge clk) disable iff (rst)
        (poll_rd_i && srq_o) |=> !srq_o);
    a_r8_srq_holds_until_poll: assert property (@(posedge clk) disable iff (rst)
        (srq_o && !poll_rd_i) |=> srq_o);
    a_r5_query_bit6_live: assert property (@(posedge clk) disable iff (rst)
        qry_rd_i |=> (qry_data_o[POS_SVC] == $past(mss)));
    a_r7_poll_bit6_flag: assert property (@(posedge clk) disable iff (rst)
        poll_rd_i |=> (poll_data_o[POS_SVC] == $past(srq_o)));
endmodule

// File: rtl/svc_status_top.sv
module svc_status_top
    import svc_pkg::*;
#(
    parameter int EVT_W = 8,
    parameter int RDY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_sum_i,
    input  logic [EVT_W-1:0] evt_reg_i,
    input  logic [EVT_W-1:0] evt_en_i,
    input  logic             rsp_pending_i,
    input  logic             err_pending_i,
    input  logic [RDY_W-1:0] rdy_reg_i,
    input  logic [RDY_W-1:0] rdy_en_i,
    input  logic             sre_wr_i,
    input  logic [7:0]       sre_wdata_i,
    input  logic             qry_rd_i,
    input  logic             poll_rd_i,
    output logic [7:0]       qry_data_o,
    output logic [7:0]       poll_data_o,
    output logic             srq_o
);
    logic [SB_W-1:0] base_status;

    svc_byte_builder #(.EVT_W(EVT_W), .RDY_W(RDY_W)) u_build (
        .op_sum_i      (op_sum_i),
        .evt_reg_i     (evt_reg_i),
        .evt_en_i      (evt_en_i),
        .rsp_pending_i (rsp_pending_i),
        .err_pending_i (err_pending_i),
        .rdy_reg_i     (rdy_reg_i),
        .rdy_en_i      (rdy_en_i),
        .base_o        (base_status)
    );

    svc_request_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .base_i      (base_status),
        .sre_wr_i    (sre_wr_i),
        .sre_wdata_i (sre_wdata_i),
        .qry_rd_i    (qry_rd_i),
        .poll_rd_i   (poll_rd_i),
        .qry_data_o  (qry_data_o),
        .poll_data_o (poll_data_o),
        .srq_o       (srq_o)
    );

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        !qry_data_o[POS_QST] && !qry_data_o[POS_RSV]
        && !poll_data_o[POS_QST] && !poll_data_o[POS_RSV]);
    a_r9_paths_agree: assert property (@(posedge clk) disable iff (rst)
        (qry_rd_i && poll_rd_i) |=> ((qry_data_o & ~SVC_MASK) == (poll_data_o & ~SVC_MASK)));
    a_r10_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (!srq_o && qry_data_o == 8'h00 && poll_data_o == 8'h00));
endmodule

// File: tb/svc_status_top_bench.sv
module svc_status_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;
    // {op, evt, evt_en, mav, err, rdy, rdy_en, sre, expected query byte}
    localparam logic [50:0] VECS [NV] = '{
        {1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00},
        {1'b1, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h80},
        {1'b0, 8'h0F, 8'hF0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h14, 8'h50},
        {1'b0, 8'h21, 8'h01, 1'b0, 1'b1, 8'h00, 8'h00, 8'h00, 8'h24},
        {1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h80, 8'h80, 8'h01, 8'h41},
        {1'b1, 8'h00, 8'h00, 1'b0, 1'b0, 8'h7F, 8'h80, 8'h7F, 8'h80},
        {1'b1, 8'hFF, 8'hFF, 1'b1, 1'b1, 8'hFF, 8'hFF, 8'h40, 8'hB5},
        {1'b1, 8'hFF, 8'hFF, 1'b1, 1'b1, 8'hFF, 8'hFF, 8'hFF, 8'hF5},
        {1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00, 8'h00, 8'h14, 8'h44}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_sum = 1'b0;
    logic [7:0] evt_reg = '0, evt_en = '0, rdy_reg = '0, rdy_en = '0;
    logic       rsp_pend = 1'b0, err_pend = 1'b0;
    logic       sre_wr = 1'b0;
    logic [7:0] sre_wdata = '0;
    logic       qry_rd = 1'b0, poll_rd = 1'b0;
    logic [7:0] qry_data, poll_data;
    logic       srq;
    logic [7:0] exp_byte;
    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    svc_status_top u_svc_status_top (
        .clk(clk), .rst(rst), .op_sum_i(op_sum), .evt_reg_i(evt_reg), .evt_en_i(evt_en),
        .rsp_pending_i(rsp_pend), .err_pending_i(err_pend), .rdy_reg_i(rdy_reg),
        .rdy_en_i(rdy_en), .sre_wr_i(sre_wr), .sre_wdata_i(sre_wdata), .qry_rd_i(qry_rd),
        .poll_rd_i(poll_rd), .qry_data_o(qry_data), .poll_data_o(poll_data), .srq_o(srq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, expv);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic write_sre(input logic [7:0] v);
        sre_wr = 1'b1; sre_wdata = v; step(); sre_wr = 1'b0;
    endtask

    task automatic do_query();
        qry_rd = 1'b1; step(); qry_rd = 1'b0;
    endtask

    task automatic do_poll();
        poll_rd = 1'b1; step(); poll_rd = 1'b0;
    endtask

    task automatic all_high();
        op_sum = 1'b1; evt_reg = 8'hFF; evt_en = 8'hFF; rsp_pend = 1'b1;
        err_pend = 1'b1; rdy_reg = 8'hFF; rdy_en = 8'hFF;
    endtask

    task automatic all_low();
        op_sum = 1'b0; evt_reg = '0; evt_en = '0; rsp_pend = 1'b0;
        err_pend = 1'b0; rdy_reg = '0; rdy_en = '0;
    endtask

    task automatic apply_reset();
        rst = 1'b1; step(); step(); rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step();
        apply_reset();
        // R10: reset state
        check("R10 srq", {7'd0, srq}, 8'h00);
        check("R10 qry", qry_data, 8'h00);
        check("R10 poll", poll_data, 8'h00);

        // R1 R2 R3 R4 R5: vector table, query byte plus matching poll bits
        for (int i = 0; i < NV; i++) begin
            {op_sum, evt_reg, evt_en, rsp_pend, err_pend, rdy_reg, rdy_en, sre_wdata, exp_byte} = VECS[i];
            write_sre(sre_wdata);
            qry_rd = 1'b1; poll_rd = 1'b1; step(); qry_rd = 1'b0; poll_rd = 1'b0;
            check("R1 R2 R3 R5 query byte", qry_data, exp_byte);
            check("R9 poll other bits", poll_data & 8'hBF, exp_byte & 8'hBF);
        end

        // R10 and R4: reset clears enable register
        all_high();
        apply_reset();
        do_query();
        check("R4 R10 enable cleared", qry_data, 8'hB5);
        check("R4 no srq after reset", {7'd0, srq}, 8'h00);

        // R6: request one edge after summary rises
        all_low();
        write_sre(8'h10);
        step();
        rsp_pend = 1'b1;
        #1;
        check("R6 not early", {7'd0, srq}, 8'h00);
        step();
        check("R6 srq raised", {7'd0, srq}, 8'h01);
        step();
        check("R6 srq held", {7'd0, srq}, 8'h01);

        // R7: poll returns flag then clears it
        do_poll();
        check("R7 poll byte", poll_data, 8'h50);
        check("R7 srq cleared", {7'd0, srq}, 8'h00);
        // R8: no re-request while summary stays high
        step(); step();
        check("R8 stays low", {7'd0, srq}, 8'h00);
        do_poll();
        check("R8 poll bit6 clear", poll_data, 8'h10);
        do_query();
        check("R5 query live summary", qry_data, 8'h50);
        // R8: fresh edge re-arms
        rsp_pend = 1'b0; step();
        rsp_pend = 1'b1; step();
        check("R8 re-request", {7'd0, srq}, 8'h01);

        // R4: enable bit 6 alone never requests
        apply_reset();
        write_sre(8'h40);
        all_high();
        step(); step();
        check("R4 bit6 enable inert", {7'd0, srq}, 8'h00);
        do_query();
        check("R4 bit6 enable query", qry_data, 8'hB5);

        // R5: 0x14 requests on error alone
        all_low();
        write_sre(8'h14);
        err_pend = 1'b1; step();
        check("R5 0x14 error request", {7'd0, srq}, 8'h01);

        // R10: reset drops an active request
        apply_reset();
        check("R10 reset drops srq", {7'd0, srq}, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule